// File: doc/BRIEF.md
# Fault-Injectable Four-Input Lookup Table

This block is a single four-input lookup-table cell of the kind used to prototype combinational logic. Its function is a 16-entry truth table kept in a register. The four lookup inputs form the index, and the selected bit is the output. A load port writes the fault-free ("golden") table.

To emulate transient faults, the cell does not gate its output wire. It keeps two tables: the golden one and the active one that drives the lookup. When the fault enable rises, a faulty table is computed from the golden table and written into the active table in one clock cycle. The faulty table can be:
- the complement of the golden table, which emulates a glitch on the output;
- the golden table with its entries swapped across one chosen input bit, which emulates a glitch on that input;
- a random word supplied by the surrounding logic, which emulates an undetermined level.

When the enable falls, the golden table is copied back unchanged. Golden-table writes that arrive while a fault is in progress are held back and committed after the release.

Top module: `flt_lut4`

## Requirements
- R1: While reset is asserted, and after it is released, both tables hold all zeros, so `lut_out` is 0 for every input value.
- R2: With no fault in progress, `lut_out` equals bit `lut_in` (read as an unsigned index 0..15) of the table. A `tbl_we` write made with no fault in progress is visible from the clock edge that samples it.
- R3: Mode code 01 (output glitch) makes the active table the bitwise complement of the golden table from the edge that samples `flt_en` high.
- R4: Mode code 10 (input glitch) with line select L in 0..3 makes entry i of the active table equal golden entry (i XOR 2^L) from the edge that samples `flt_en` high.
- R5: Mode code 11 (undetermined level) loads the active table with `flt_noise` as sampled on the entry edge, so `lut_out` equals `flt_noise[lut_in]` at entry time.
- R6: Mode code 00 makes the active table equal to the golden table during the fault.
- R7: While the fault is held, changes to `flt_mode`, `flt_line` and `flt_noise` have no effect, and the active table is unchanged.
- R8: On the first edge that samples `flt_en` low after a fault, the active table becomes the golden table exactly as it was before the fault.
- R9: Writes made while a fault is in progress do not change the golden table. The last such write is committed one cycle after the release edge, unless a fresh write in that cycle overrides it.
- R10: A write sampled on the same edge as the rising `flt_en` is deferred under R9, and the faulty table is computed from the previous golden table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lut_in | input | 4 | Lookup index (the four function inputs) |
| lut_out | output | 1 | Selected bit of the active table |
| tbl_we | input | 1 | Golden-table write strobe |
| tbl_wdata | input | 16 | Golden-table write value, bit i is the entry for index i |
| flt_en | input | 1 | Fault enable level; rising edge injects, falling edge releases |
| flt_mode | input | 2 | Fault kind: 00 none, 01 output, 10 input line, 11 random |
| flt_line | input | 2 | Input line for mode 10 |
| flt_noise | input | 16 | Random word loaded for mode 11 |

## Verification
The assertions assume that `flt_en` is a synchronous level, and that `flt_mode`, `flt_line` and `flt_noise` only matter on the entry edge. They also assume the internal reset synchronizer has released before any fault starts. The stimulus drives every input only at falling clock edges and waits out the reset release. It then mixes the following:
- directed sequences for write collisions at entry and during a fault;
- mode and noise changes during a held fault;
- seeded random golden tables, modes, lines and noise words.

After each cycle, all 16 table entries are swept through the lookup inputs.

// File: rtl/flt_lut_pkg.sv
package flt_lut_pkg;
  typedef enum logic [1:0] {
    FM_NONE    = 2'b00,
    FM_OUT_INV = 2'b01,
    FM_IN_INV  = 2'b10,
    FM_RANDOM  = 2'b11
  } flt_mode_e;
endpackage

// File: rtl/flt_lut_xform.sv
module flt_lut_xform
  import flt_lut_pkg::*;
#(
  parameter int N_IN   = 4,
  localparam int TBL_W  = 1 << N_IN,
  localparam int LSEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic [TBL_W-1:0]  gold,
  input  flt_mode_e         mode,
  input  logic [LSEL_W-1:0] line,
  input  logic [TBL_W-1:0]  noise,
  output logic [TBL_W-1:0]  faulty
);
  // One permuted table per input line: entries paired across that index bit.
  logic [N_IN-1:0][TBL_W-1:0] perm;

  for (genvar l = 0; l < N_IN; l++) begin : g_line
    for (genvar i = 0; i < TBL_W; i++) begin : g_ent
      assign perm[l][i] = gold[i ^ (1 << l)];
    end
  end

  always_comb begin
    unique case (mode)
      FM_NONE:    faulty = gold;
      FM_OUT_INV: faulty = ~gold;
      FM_IN_INV:  faulty = perm[line];
      FM_RANDOM:  faulty = noise;
      default:    faulty = gold;
    endcase
  end
endmodule

// File: rtl/flt_lut_ctrl.sv
module flt_lut_ctrl #(
  parameter int N_IN = 4,
  localparam int TBL_W = 1 << N_IN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flt_en,
  input  logic             wr_req,
  input  logic [TBL_W-1:0] wr_data,
  output logic             fault_on,
  output logic             enter,
  output logic             leave,
  output logic             gold_we,
  output logic [TBL_W-1:0] gold_wdata
);
  logic             on_n;
  logic             pend_v_q, pend_v_n;
  logic [TBL_W-1:0] pend_d_q, pend_d_n;
  logic             pend_d_en;
  logic             idle;

  assign enter = flt_en & ~fault_on;
  assign leave = ~flt_en & fault_on;
  assign idle  = ~flt_en & ~fault_on;
  assign on_n  = flt_en;

  always_comb begin
    gold_we    = 1'b0;
    gold_wdata = wr_data;
    pend_v_n   = pend_v_q;
    pend_d_n   = pend_d_q;
    pend_d_en  = 1'b0;
    if (idle) begin
      if (wr_req) begin
        gold_we  = 1'b1;
        pend_v_n = 1'b0;
      end else if (pend_v_q) begin
        gold_we    = 1'b1;
        gold_wdata = pend_d_q;
        pend_v_n   = 1'b0;
      end
    end else if (wr_req) begin
      pend_v_n  = 1'b1;
      pend_d_n  = wr_data;
      pend_d_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_on <= 1'b0;
      pend_v_q <= 1'b0;
    end else begin
      fault_on <= on_n;
      pend_v_q <= pend_v_n;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_d_en) pend_d_q <= pend_d_n;
  end
endmodule

// File: rtl/flt_lut_table.sv
module flt_lut_table #(
  parameter int N_IN = 4,
  localparam int TBL_W = 1 << N_IN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter,
  input  logic             leave,
  input  logic             gold_we,
  input  logic [TBL_W-1:0] gold_wdata,
  input  logic [TBL_W-1:0] faulty,
  input  logic [N_IN-1:0]  idx,
  output logic             bit_out,
  output logic [TBL_W-1:0] gold_q,
  output logic [TBL_W-1:0] act_q
);
  logic [TBL_W-1:0] gold_n, act_n;
  logic             gold_en, act_en;

  always_comb begin
    gold_en = gold_we;
    gold_n  = gold_wdata;
    act_en  = 1'b1;
    if (enter)        act_n = faulty;
    else if (leave)   act_n = gold_q;
    else if (gold_we) act_n = gold_wdata;
    else begin
      act_n  = act_q;
      act_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gold_q <= '0;
      act_q  <= '0;
    end else begin
      if (gold_en) gold_q <= gold_n;
      if (act_en)  act_q  <= act_n;
    end
  end

  assign bit_out = act_q[idx];
endmodule

// File: rtl/flt_lut4.sv
module flt_lut4
  import flt_lut_pkg::*;
#(
  parameter int N_IN = 4,
  localparam int TBL_W  = 1 << N_IN,
  localparam int LSEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   lut_in,
  output logic              lut_out,
  input  logic              tbl_we,
  input  logic [TBL_W-1:0]  tbl_wdata,
  input  logic              flt_en,
  input  logic [1:0]        flt_mode,
  input  logic [LSEL_W-1:0] flt_line,
  input  logic [TBL_W-1:0]  flt_noise
);
  logic             rst_meta, rst_s;
  logic             fault_on, enter, leave, gold_we;
  logic [TBL_W-1:0] gold_wdata, faulty, gold_q, act_q;
  flt_mode_e        mode;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  assign mode = flt_mode_e'(flt_mode);

  flt_lut_ctrl #(.N_IN(N_IN)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .flt_en(flt_en), .wr_req(tbl_we),
    .wr_data(tbl_wdata), .fault_on(fault_on), .enter(enter), .leave(leave),
    .gold_we(gold_we), .gold_wdata(gold_wdata)
  );

  flt_lut_xform #(.N_IN(N_IN)) u_xform (
    .gold(gold_q), .mode(mode), .line(flt_line), .noise(flt_noise),
    .faulty(faulty)
  );

  flt_lut_table #(.N_IN(N_IN)) u_table (
    .clk(clk), .rst_n(rst_s), .enter(enter), .leave(leave),
    .gold_we(gold_we), .gold_wdata(gold_wdata), .faulty(faulty),
    .idx(lut_in), .bit_out(lut_out), .gold_q(gold_q), .act_q(act_q)
  );

  p_out_inv_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (flt_en && !fault_on && flt_mode == 2'b01) |=> act_q == ~$past(gold_q));

  p_noise_load_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (flt_en && !fault_on && flt_mode == 2'b11) |=> act_q == $past(flt_noise));

  p_no_fault_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (flt_en && !fault_on && flt_mode == 2'b00) |=> act_q == $past(gold_q));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (fault_on && flt_en) |=> $stable(act_q));

  p_restore_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (fault_on && !flt_en) |=> act_q == $past(gold_q));

  p_gold_frozen_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (fault_on || flt_en) |=> $stable(gold_q));
endmodule

// File: tb/test_flt_lut4.sv
module test_flt_lut4;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  lut_in;
  logic        lut_out;
  logic        tbl_we;
  logic [15:0] tbl_wdata;
  logic        flt_en;
  logic [1:0]  flt_mode;
  logic [1:0]  flt_line;
  logic [15:0] flt_noise;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  flt_lut4 i_flt_lut4 (
    .clk(clk), .rst_n(rst_n), .lut_in(lut_in), .lut_out(lut_out),
    .tbl_we(tbl_we), .tbl_wdata(tbl_wdata), .flt_en(flt_en),
    .flt_mode(flt_mode), .flt_line(flt_line), .flt_noise(flt_noise)
  );

  function automatic logic [15:0] exp_tbl(input logic [15:0] g, input logic [1:0] m,
                                          input logic [1:0] l, input logic [15:0] nz);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) begin
      case (m)
        2'b00: r[i] = g[i];
        2'b01: r[i] = ~g[i];
        2'b10: r[i] = g[i ^ (1 << l)];
        default: r[i] = nz[i];
      endcase
    end
    return r;
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sweep(input logic [15:0] exp, input string tag);
    logic [15:0] got;
    for (int i = 0; i < 16; i++) begin
      lut_in = 4'(i);
      #0.5;
      got[i] = lut_out;
    end
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: table seen %h expected %h", tag, got, exp);
    end
  endtask

  task automatic write_idle(input logic [15:0] d);
    tbl_we = 1'b1; tbl_wdata = d;
    cyc();
    tbl_we = 1'b0;
  endtask

  task automatic fault_round(input logic [15:0] g, input logic [1:0] m,
                             input logic [1:0] l, input logic [15:0] nz, input string tag);
    flt_en = 1'b1; flt_mode = m; flt_line = l; flt_noise = nz;
    cyc();
    sweep(exp_tbl(g, m, l, nz), tag);
    flt_en = 1'b0;
    cyc();
    sweep(g, "R8 release");
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] g;
    logic [15:0] fx;
    void'($urandom(32'd7331));
    rst_n = 1'b0; lut_in = '0; tbl_we = 1'b0; tbl_wdata = '0;
    flt_en = 1'b0; flt_mode = 2'b00; flt_line = 2'b00; flt_noise = '0;
    cyc();
    sweep(16'h0000, "R1 in reset");
    rst_n = 1'b1;
    cyc(); cyc(); cyc();
    sweep(16'h0000, "R1 after release");

    // R2: idle writes
    g = 16'hB5D3; write_idle(g);
    sweep(g, "R2 write");
    g = 16'h6A0F; write_idle(g);
    sweep(g, "R2 rewrite");

    // R3 with R7: inputs changed while held
    flt_en = 1'b1; flt_mode = 2'b01; flt_line = 2'b00; flt_noise = 16'h1234;
    cyc();
    fx = ~g;
    sweep(fx, "R3 output glitch");
    flt_mode = 2'b11; flt_noise = 16'hFFFF; flt_line = 2'b11;
    cyc();
    sweep(fx, "R7 mode change ignored");
    flt_mode = 2'b10;
    cyc();
    sweep(fx, "R7 still held");
    flt_en = 1'b0;
    cyc();
    sweep(g, "R8 restore after R3");

    // R4: each line
    for (int l = 0; l < 4; l++) fault_round(g, 2'b10, 2'(l), 16'h0, "R4 input glitch");
    // R5 and R6
    fault_round(g, 2'b11, 2'b01, 16'hC3A5, "R5 random word");
    fault_round(g, 2'b11, 2'b00, 16'h0000, "R5 random zero");
    fault_round(g, 2'b00, 2'b10, 16'hFFFF, "R6 no fault");

    // R9: writes during fault held, last wins
    flt_en = 1'b1; flt_mode = 2'b01;
    cyc();
    tbl_we = 1'b1; tbl_wdata = 16'h1111;
    cyc();
    tbl_wdata = 16'h2222;
    cyc();
    tbl_we = 1'b0;
    sweep(~g, "R9 fault table unaffected");
    flt_en = 1'b0;
    cyc();
    sweep(g, "R9 release restores old golden");
    cyc();
    g = 16'h2222;
    sweep(g, "R9 held write committed");
    fault_round(g, 2'b00, 2'b00, 16'h0, "R9 golden after commit");

    // R9: fresh write in commit cycle wins
    flt_en = 1'b1; flt_mode = 2'b01;
    cyc();
    tbl_we = 1'b1; tbl_wdata = 16'h3333;
    cyc();
    tbl_we = 1'b0; flt_en = 1'b0;
    cyc();
    sweep(g, "R9 release before override");
    tbl_we = 1'b1; tbl_wdata = 16'h4444;
    cyc();
    tbl_we = 1'b0;
    g = 16'h4444;
    sweep(g, "R9 fresh write overrides held");
    cyc();
    sweep(g, "R9 no late commit");

    // R10: write on the entry edge
    flt_en = 1'b1; flt_mode = 2'b10; flt_line = 2'b10;
    tbl_we = 1'b1; tbl_wdata = 16'h9C01;
    cyc();
    tbl_we = 1'b0;
    sweep(exp_tbl(g, 2'b10, 2'b10, 16'h0), "R10 fault from old golden");
    flt_en = 1'b0;
    cyc();
    sweep(g, "R10 release old golden");
    cyc();
    g = 16'h9C01;
    sweep(g, "R10 deferred write");

    // Random rounds
    for (int k = 0; k < 40; k++) begin
      logic [1:0] m;
      logic [1:0] l;
      logic [15:0] nz;
      g  = 16'($urandom());
      m  = 2'($urandom());
      l  = 2'($urandom());
      nz = 16'($urandom());
      write_idle(g);
      sweep(g, "R2 random write");
      fault_round(g, m, l, nz, (m == 2'b01) ? "R3 random" : (m == 2'b10) ? "R4 random" :
                  (m == 2'b11) ? "R5 random" : "R6 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule